// File: doc/BRIEF.md
# Message-signalled interrupt vector table controller

This block holds a per-vector table of interrupt messages and the matching array of pending bits for a device with a parameterised number of vectors. Software reaches both regions through a register port that takes 32-bit or 64-bit accesses. Each table entry holds a 64-bit message address, a 32-bit message data word and a control word whose bit 0 masks that vector. The pending array can only be read from the port.

A device raises an interrupt by pulsing an event on one vector number. If the function is enabled, the function is not masked and the vector is not masked, the message leaves at once on a valid/ready output as {address, data, vector}. In every other case the vector's pending bit is set instead.

A scanner walks the vectors one per clock and wraps at the last one. It delivers every vector that is pending and deliverable, and it clears that vector's pending bit. Because of this, a pending vector goes out after its own mask clears, and also after the function mask clears. When the function mask falls, the scanner restarts at vector 0, so the replay runs in ascending vector order.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset every table entry has control word 1 (masked) and address and data 0, every pending bit is 0, and `msg_valid` is 0.
- R2: Table entry n starts at byte offset 16*n. Within an entry, 32-bit accesses at sub-offset 0x0, 0x4, 0x8 and 0xC reach the low address, the high address, the data and the control word. Read data appears in bits 31:0, with bits 63:32 at zero.
- R3: A 64-bit access at sub-offset 0x0 carries {high address, low address}, and one at 0x8 carries {control, data}. In both cases the higher field is in bits 63:32.
- R4: The following accesses read zero and writes to them change nothing: a 64-bit access at sub-offset 0x4 or 0xC, any offset whose low two bits are not zero, and any entry index of NUM_VEC or more.
- R5: Pending bit v lives in 64-bit word v/64, at bit v%64. Word w sits at pending-region byte offset 8*w. A 32-bit read at +0 returns bits 31:0 of the word and one at +4 returns bits 63:32. A 64-bit read at +0 returns the whole word. Writes to the pending region are ignored.
- R6: In `ctl_word`, bit 15 is enable and bit 14 is the function mask. An event on a vector is issued as a message in the next cycle when all of these hold: the function is enabled, the function is not masked, the vector's control bit 0 is clear, the output is free and the scanner is not issuing.
- R7: An event that is not issued at once sets that vector's pending bit.
- R8: When a table write clears the mask of a pending vector while the function is enabled and not masked, that vector's message is issued and its pending bit is cleared.
- R9: When the function mask goes from 1 to 0, the scan restarts at vector 0. It issues each pending, unmasked vector in ascending order and clears its pending bit. Pending vectors that are still masked keep their pending bit.
- R10: While `msg_valid` is 1 and `msg_ready` is 0, the vector, address and data outputs hold their values and the scan stalls.
- R11: Scan issues take priority over events. An event that arrives while the scan is stalled or issuing is recorded as pending and is issued later by the scan.
- R12: No message is issued while the function is disabled or masked. Vectors that become pending in that state are issued once the function is enabled and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_pba | input | 1 | Region select: 1 selects the pending array, 0 selects the table |
| reg_is64 | input | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| reg_off | input | OFF_W | Byte offset within the selected region |
| reg_wdata | input | 64 | Write data; a 32-bit access uses bits 31:0 |
| reg_rdata | output | 64 | Combinational read data for the current offset |
| ctl_word | input | 16 | Capability control word: bit 15 enable, bit 14 function mask |
| evt_valid | input | 1 | Interrupt event strobe |
| evt_vec | input | VW | Vector number of the event |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_vec | output | VW | Vector number of the message |

## Verification
The hard case is a scan issue and a device event that both want the single output in the same cycle. The bench provokes it in two steps. First it holds `msg_ready` low during a function-unmask replay, so the scan stalls on a pending vector. Then it fires an event on a different, deliverable vector. That event must appear in the pending array while the stall lasts. Once ready returns, the scoreboard expects the messages in scan order with the event's vector placed by its index, and it expects no vector twice and none lost.

// File: rtl/msix_pkg.sv
package msix_pkg;

    localparam int CTL_MASK_BIT = 14;
    localparam int CTL_EN_BIT   = 15;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } msix_msg_t;

    typedef struct packed {
        logic lo;
        logic hi;
        logic dat;
        logic ctl;
    } tbl_sel_t;

    typedef enum logic [1:0] {
        PBA_NONE,
        PBA_LO,
        PBA_HI,
        PBA_FULL
    } pba_sel_e;

    // Which table fields a given sub-offset and access size touch
    function automatic tbl_sel_t tbl_decode(input logic [3:0] sub, input logic is64);
        tbl_sel_t s;
        s = '0;
        if (sub[1:0] == 2'b00) begin
            if (is64) begin
                s.lo  = (sub == 4'h0);
                s.hi  = (sub == 4'h0);
                s.dat = (sub == 4'h8);
                s.ctl = (sub == 4'h8);
            end else begin
                s.lo  = (sub[3:2] == 2'd0);
                s.hi  = (sub[3:2] == 2'd1);
                s.dat = (sub[3:2] == 2'd2);
                s.ctl = (sub[3:2] == 2'd3);
            end
        end
        return s;
    endfunction

    function automatic pba_sel_e pba_decode(input logic [2:0] sub, input logic is64);
        pba_sel_e s;
        s = PBA_NONE;
        if (sub[1:0] == 2'b00) begin
            if (is64) s = (sub[2] == 1'b0) ? PBA_FULL : PBA_NONE;
            else      s = (sub[2] == 1'b0) ? PBA_LO : PBA_HI;
        end
        return s;
    endfunction

endpackage

// File: rtl/msix_table.sv
module msix_table
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int OFF_W   = 16,
    parameter int VW      = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               is64,
    input  logic [OFF_W-1:0]   off,
    input  logic [63:0]        wdata,
    output logic [63:0]        rdata,
    output logic [NUM_VEC-1:0] mask_o,
    input  logic [VW-1:0]      idx_a,
    input  logic [VW-1:0]      idx_b,
    output msix_msg_t          ent_a,
    output msix_msg_t          ent_b
);

    logic [31:0] lo_q  [NUM_VEC];
    logic [31:0] hi_q  [NUM_VEC];
    logic [31:0] dat_q [NUM_VEC];
    logic [31:0] ctl_q [NUM_VEC];

    logic [OFF_W-5:0] idx_full;
    logic [VW-1:0]    idx;
    logic             in_range;
    tbl_sel_t         sel;

    assign idx_full = off[OFF_W-1:4];
    assign idx      = idx_full[VW-1:0];
    assign in_range = int'(idx_full) < NUM_VEC;
    assign sel      = tbl_decode(off[3:0], is64);

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q[i]  <= '0;
                hi_q[i]  <= '0;
                dat_q[i] <= '0;
                ctl_q[i] <= 32'd1;
            end else if (wr_en && in_range && idx == VW'(i)) begin
                if (sel.lo)  lo_q[i]  <= wdata[31:0];
                if (sel.hi)  hi_q[i]  <= is64 ? wdata[63:32] : wdata[31:0];
                if (sel.dat) dat_q[i] <= wdata[31:0];
                if (sel.ctl) ctl_q[i] <= is64 ? wdata[63:32] : wdata[31:0];
            end
        end
        assign mask_o[i] = ctl_q[i][0];
    end

    always_comb begin
        rdata = '0;
        if (in_range) begin
            if (is64) begin
                if (sel.lo)       rdata = {hi_q[idx], lo_q[idx]};
                else if (sel.dat) rdata = {ctl_q[idx], dat_q[idx]};
            end else begin
                if (sel.lo)  rdata[31:0] = lo_q[idx];
                if (sel.hi)  rdata[31:0] = hi_q[idx];
                if (sel.dat) rdata[31:0] = dat_q[idx];
                if (sel.ctl) rdata[31:0] = ctl_q[idx];
            end
        end
    end

    assign ent_a = '{addr: {hi_q[idx_a], lo_q[idx_a]}, data: dat_q[idx_a]};
    assign ent_b = '{addr: {hi_q[idx_b], lo_q[idx_b]}, data: dat_q[idx_b]};

    // R4
    bad_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(in_range && (|sel))) |=> $stable(mask_o));

endmodule

// File: rtl/msix_pending.sv
module msix_pending
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int OFF_W   = 16,
    parameter int VW      = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic [VW-1:0]      set_vec,
    input  logic               clr_en,
    input  logic [VW-1:0]      clr_vec,
    input  logic               is64,
    input  logic [OFF_W-1:0]   off,
    output logic [63:0]        rdata,
    output logic [NUM_VEC-1:0] pend_o
);

    localparam int NUM_WORDS = NUM_VEC / 64 + 1;
    localparam int PAD_W     = NUM_WORDS * 64;

    logic [NUM_VEC-1:0] pend_q;
    logic [PAD_W-1:0]   pad;
    logic [OFF_W-4:0]   word_full;
    logic [63:0]        word_val;
    pba_sel_e           sel;

    // a set on the same vector as a clear wins, so no event is lost
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            if (clr_en) pend_q[clr_vec] <= 1'b0;
            if (set_en) pend_q[set_vec] <= 1'b1;
        end
    end

    assign pend_o    = pend_q;
    assign pad       = {{(PAD_W - NUM_VEC){1'b0}}, pend_q};
    assign word_full = off[OFF_W-1:3];
    assign sel       = pba_decode(off[2:0], is64);

    always_comb begin
        word_val = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (int'(word_full) == w) word_val = pad[w*64 +: 64];
        end
        case (sel)
            PBA_LO:   rdata = {32'd0, word_val[31:0]};
            PBA_HI:   rdata = {32'd0, word_val[63:32]};
            PBA_FULL: rdata = word_val;
            default:  rdata = '0;
        endcase
    end

    // R7
    set_pend_chk: assert property (@(posedge clk) disable iff (rst)
        set_en |=> pend_q[$past(set_vec)]);

    // R8
    clr_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(set_en && set_vec == clr_vec)) |=> !pend_q[$past(clr_vec)]);

endmodule

// File: rtl/msix_emit.sv
module msix_emit
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int VW      = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fn_on,
    input  logic               rescan,
    input  logic [NUM_VEC-1:0] mask,
    input  logic [NUM_VEC-1:0] pend,
    input  logic               evt_valid,
    input  logic [VW-1:0]      evt_vec,
    input  msix_msg_t          ent_scan,
    input  msix_msg_t          ent_evt,
    output logic [VW-1:0]      scan_ptr,
    output logic               set_en,
    output logic [VW-1:0]      set_vec,
    output logic               clr_en,
    output logic [VW-1:0]      clr_vec,
    input  logic               msg_ready,
    output logic               msg_valid,
    output logic [VW-1:0]      msg_vec,
    output msix_msg_t          msg
);

    logic slot_free, scan_hit, scan_load, evt_in, evt_ok, evt_load;

    assign slot_free = !msg_valid || msg_ready;
    assign scan_hit  = fn_on && pend[scan_ptr] && !mask[scan_ptr];
    assign scan_load = scan_hit && slot_free;
    assign evt_in    = evt_valid && (int'(evt_vec) < NUM_VEC);
    assign evt_ok    = evt_in && fn_on && !mask[evt_vec];
    assign evt_load  = evt_ok && slot_free && !scan_load;

    assign set_en  = evt_in && !evt_load;
    assign set_vec = evt_vec;
    assign clr_en  = scan_load;
    assign clr_vec = scan_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_ptr <= '0;
        end else if (rescan) begin
            scan_ptr <= '0;
        end else if (!(scan_hit && !slot_free)) begin
            scan_ptr <= (scan_ptr == VW'(NUM_VEC - 1)) ? '0 : scan_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_vec   <= '0;
            msg       <= '0;
        end else if (slot_free) begin
            msg_valid <= scan_load || evt_load;
            if (scan_load) begin
                msg_vec <= scan_ptr;
                msg     <= ent_scan;
            end else if (evt_load) begin
                msg_vec <= evt_vec;
                msg     <= ent_evt;
            end
        end
    end

    // R10
    msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vec) && $stable(msg)));

    // R12
    fn_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_free && !fn_on) |=> !msg_valid);

endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int OFF_W   = 16,
    localparam int VW     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_pba,
    input  logic             reg_is64,
    input  logic [OFF_W-1:0] reg_off,
    input  logic [63:0]      reg_wdata,
    output logic [63:0]      reg_rdata,
    input  logic [15:0]      ctl_word,
    input  logic             evt_valid,
    input  logic [VW-1:0]    evt_vec,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [63:0]      msg_addr,
    output logic [31:0]      msg_data,
    output logic [VW-1:0]    msg_vec
);

    logic fn_mask_q, fn_en_q, fn_on, rescan;
    logic unused_ctl;

    logic [NUM_VEC-1:0] mask, pend;
    logic [VW-1:0]      scan_ptr, set_vec, clr_vec;
    logic               set_en, clr_en;
    logic [63:0]        tbl_rdata, pba_rdata;
    msix_msg_t          ent_scan, ent_evt, msg;

    assign unused_ctl = ^ctl_word[CTL_MASK_BIT-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            fn_mask_q <= 1'b1;
            fn_en_q   <= 1'b0;
        end else begin
            fn_mask_q <= ctl_word[CTL_MASK_BIT];
            fn_en_q   <= ctl_word[CTL_EN_BIT];
        end
    end

    assign fn_on  = fn_en_q && !fn_mask_q;
    assign rescan = fn_mask_q && !ctl_word[CTL_MASK_BIT];

    msix_table #(.NUM_VEC(NUM_VEC), .OFF_W(OFF_W), .VW(VW)) u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr && !reg_pba),
        .is64   (reg_is64),
        .off    (reg_off),
        .wdata  (reg_wdata),
        .rdata  (tbl_rdata),
        .mask_o (mask),
        .idx_a  (scan_ptr),
        .idx_b  (evt_vec),
        .ent_a  (ent_scan),
        .ent_b  (ent_evt)
    );

    msix_pending #(.NUM_VEC(NUM_VEC), .OFF_W(OFF_W), .VW(VW)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_en  (set_en),
        .set_vec (set_vec),
        .clr_en  (clr_en),
        .clr_vec (clr_vec),
        .is64    (reg_is64),
        .off     (reg_off),
        .rdata   (pba_rdata),
        .pend_o  (pend)
    );

    msix_emit #(.NUM_VEC(NUM_VEC), .VW(VW)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .fn_on     (fn_on),
        .rescan    (rescan),
        .mask      (mask),
        .pend      (pend),
        .evt_valid (evt_valid),
        .evt_vec   (evt_vec),
        .ent_scan  (ent_scan),
        .ent_evt   (ent_evt),
        .scan_ptr  (scan_ptr),
        .set_en    (set_en),
        .set_vec   (set_vec),
        .clr_en    (clr_en),
        .clr_vec   (clr_vec),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg_vec   (msg_vec),
        .msg       (msg)
    );

    assign reg_rdata = reg_pba ? pba_rdata : tbl_rdata;
    assign msg_addr  = msg.addr;
    assign msg_data  = msg.data;

    // R9
    rescan_start_chk: assert property (@(posedge clk) disable iff (rst)
        rescan |=> (scan_ptr == '0));

endmodule

// File: tb/msix_vec_ctrl_test.sv
module msix_vec_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 72;
    localparam int VWT        = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_pba = 1'b0, reg_is64 = 1'b0;
    logic [15:0] reg_off = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [15:0] ctl_word = 16'h4000;
    logic        evt_valid = 1'b0;
    logic [VWT-1:0] evt_vec = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic [VWT-1:0] msg_vec;

    typedef struct packed {
        logic [VWT-1:0] vec;
        logic [63:0]    addr;
        logic [31:0]    data;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msix_vec_ctrl #(.NUM_VEC(NV), .OFF_W(16)) uut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_pba(reg_pba), .reg_is64(reg_is64),
        .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctl_word(ctl_word), .evt_valid(evt_valid), .evt_vec(evt_vec),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data), .msg_vec(msg_vec)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic pba, input logic is64, input logic [15:0] off, input logic [63:0] d);
        @(posedge clk); #1;
        reg_pba = pba; reg_is64 = is64; reg_off = off; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic pba, input logic is64, input logic [15:0] off, output logic [63:0] v);
        @(posedge clk); #1;
        reg_pba = pba; reg_is64 = is64; reg_off = off;
        #1 v = reg_rdata;
    endtask

    task automatic event_on(input int v);
        @(posedge clk); #1;
        evt_valid = 1'b1; evt_vec = VWT'(v);
        @(posedge clk); #1;
        evt_valid = 1'b0;
    endtask

    task automatic expect_msg(input int v, input logic [63:0] a, input logic [31:0] d);
        exp_q.push_back('{vec: VWT'(v), addr: a, data: d});
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: every accepted message must match the head of the queue (R6, R8, R9)
    always @(posedge clk) begin
        if (!rst && msg_valid && msg_ready) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R6 unexpected message: actual vec %0d addr %h data %h expected none",
                         msg_vec, msg_addr, msg_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (msg_vec !== e.vec || msg_addr !== e.addr || msg_data !== e.data) begin
                    n_fail++;
                    $display("FAIL R6 message: actual vec %0d addr %h data %h expected vec %0d addr %h data %h",
                             msg_vec, msg_addr, msg_data, e.vec, e.addr, e.data);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [63:0] v;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(0, 0, 16'h000C, v); chk("R1 ctl0", v, 64'h1);
        rd(0, 0, 16'h0030, v); chk("R1 lo3", v, 64'h0);
        rd(1, 1, 16'h0000, v); chk("R1 pba0", v, 64'h0);
        chk("R1 msg_valid", {63'd0, msg_valid}, 64'h0);

        // R2 32-bit field layout, entry 2
        wr(0, 0, 16'h0020, 64'h1000_0020);
        wr(0, 0, 16'h0024, 64'h0000_000A);
        wr(0, 0, 16'h0028, 64'h0000_0055);
        wr(0, 0, 16'h002C, 64'h0000_0000);
        rd(0, 0, 16'h0020, v); chk("R2 lo", v, 64'h1000_0020);
        rd(0, 0, 16'h0024, v); chk("R2 hi", v, 64'hA);
        rd(0, 0, 16'h0028, v); chk("R2 data", v, 64'h55);
        rd(0, 0, 16'h002C, v); chk("R2 ctl", v, 64'h0);

        // R3 64-bit access, entry 5
        wr(0, 1, 16'h0050, 64'h0000_000B_2000_0050);
        wr(0, 1, 16'h0058, 64'h0000_0000_0000_0066);
        rd(0, 1, 16'h0050, v); chk("R3 addr64", v, 64'h0000_000B_2000_0050);
        rd(0, 1, 16'h0058, v); chk("R3 ctldata64", v, 64'h66);
        rd(0, 0, 16'h0054, v); chk("R3 hi32", v, 64'hB);

        // R4 unsupported sub-offsets and range
        wr(0, 1, 16'h0014, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(0, 0, 16'h0014, v); chk("R4 64 at 4 write", v, 64'h0);
        rd(0, 0, 16'h001C, v); chk("R4 64 at 4 ctl", v, 64'h1);
        rd(0, 1, 16'h005C, v); chk("R4 64 at C read", v, 64'h0);
        wr(0, 0, 16'h0011, 64'h1234_5678);
        rd(0, 0, 16'h0010, v); chk("R4 misaligned write", v, 64'h0);
        rd(0, 0, 16'h0021, v); chk("R4 misaligned read", v, 64'h0);
        wr(0, 0, 16'h0500, 64'hDEAD_BEEF);
        rd(0, 0, 16'h0500, v); chk("R4 out of range", v, 64'h0);

        // R6 direct delivery
        ctl_word = 16'h8000;
        wait_cyc(3);
        expect_msg(2, 64'h0000_000A_1000_0020, 32'h55);
        event_on(2);
        expect_msg(5, 64'h0000_000B_2000_0050, 32'h66);
        event_on(5);
        wait_cyc(5);
        chk("R6 queue drained", 64'(exp_q.size()), 64'h0);

        // R7 masked vectors become pending; R5 layout
        event_on(3);
        event_on(35);
        event_on(65);
        wait_cyc(3);
        rd(1, 0, 16'h0000, v); chk("R7 pba w0 lo", v, 64'h8);
        rd(1, 0, 16'h0004, v); chk("R5 pba w0 hi", v, 64'h8);
        rd(1, 0, 16'h0008, v); chk("R5 pba w1 lo", v, 64'h2);
        rd(1, 1, 16'h0000, v); chk("R5 pba w0 full", v, 64'h0000_0008_0000_0008);
        wr(1, 1, 16'h0000, 64'h0);
        rd(1, 1, 16'h0000, v); chk("R5 pba write ignored", v, 64'h0000_0008_0000_0008);

        // R8 unmasking a pending vector
        wr(0, 0, 16'h0030, 64'h5000_0030);
        wr(0, 0, 16'h0038, 64'h0000_0033);
        expect_msg(3, 64'h0000_0000_5000_0030, 32'h33);
        wr(0, 0, 16'h003C, 64'h0);
        wait_cyc(100);
        rd(1, 0, 16'h0000, v); chk("R8 pending cleared", v, 64'h0);
        chk("R8 queue drained", 64'(exp_q.size()), 64'h0);

        // R12 function masked: events pend, nothing issued
        ctl_word = 16'hC000;
        wait_cyc(2);
        event_on(2);
        event_on(5);
        wr(0, 0, 16'h0410, 64'h4000_0410);
        wr(0, 0, 16'h0418, 64'h0000_0088);
        wr(0, 0, 16'h041C, 64'h0);
        wr(0, 0, 16'h0060, 64'h3000_0060);
        wr(0, 0, 16'h0068, 64'h0000_0077);
        wr(0, 0, 16'h006C, 64'h0);
        wait_cyc(100);
        rd(1, 0, 16'h0000, v); chk("R12 masked pba lo", v, 64'h24);
        rd(1, 0, 16'h0004, v); chk("R12 masked pba hi", v, 64'h8);
        rd(1, 0, 16'h0008, v); chk("R12 masked pba w1", v, 64'h2);

        // R9 replay on function unmask with a stalled output (R10, R11)
        msg_ready = 1'b0;
        expect_msg(2, 64'h0000_000A_1000_0020, 32'h55);
        expect_msg(5, 64'h0000_000B_2000_0050, 32'h66);
        expect_msg(6, 64'h0000_0000_3000_0060, 32'h77);
        expect_msg(65, 64'h0000_0000_4000_0410, 32'h88);
        ctl_word = 16'h8000;
        wait_cyc(10);
        chk("R10 valid held", {63'd0, msg_valid}, 64'h1);
        chk("R10 vec held", 64'(msg_vec), 64'd2);
        event_on(6);
        wait_cyc(5);
        rd(1, 0, 16'h0000, v); chk("R11 event pended during scan", v, 64'h60);
        chk("R10 vec still held", 64'(msg_vec), 64'd2);
        chk("R10 addr held", msg_addr, 64'h0000_000A_1000_0020);
        msg_ready = 1'b1;
        wait_cyc(100);
        rd(1, 0, 16'h0000, v); chk("R9 pba lo after replay", v, 64'h0);
        rd(1, 0, 16'h0004, v); chk("R9 masked stays pending", v, 64'h8);
        rd(1, 0, 16'h0008, v); chk("R9 pba w1 after replay", v, 64'h0);
        chk("R9 queue drained", 64'(exp_q.size()), 64'h0);

        // R12 disabled function, then enabled
        ctl_word = 16'h0000;
        wait_cyc(2);
        event_on(2);
        wait_cyc(100);
        rd(1, 0, 16'h0000, v); chk("R12 disabled pends", v, 64'h4);
        expect_msg(2, 64'h0000_000A_1000_0020, 32'h55);
        ctl_word = 16'h8000;
        wait_cyc(100);
        rd(1, 0, 16'h0000, v); chk("R12 delivered after enable", v, 64'h0);
        chk("R12 queue drained", 64'(exp_q.size()), 64'h0);

        report();
    end

endmodule